// File: doc/BRIEF.md
# Word-Organized Memory with Byte Writes and Completion Pulse

This block is a main memory that a processor-side requester reaches over a small request/complete bus. The memory is organized as words of `DATA_W` bits (four bytes with the defaults). The address input is a byte address. Its low bits name a byte lane and its upper bits name the word, so byte addresses 0, 4, 8 and so on fall on consecutive words. The requester presents an address, and for writes a data value. It then raises either the read strobe or the write strobe and keeps it high until the block shows it is ready.

Once a request is accepted, the block performs the access after a fixed access latency of `ACC_LAT` clock cycles. In that same cycle it pulses the completion output `mfc` for one cycle. For a read, the addressed word appears on `rdata` alongside that pulse.

A second, longer parameter, `CYC_TIME`, sets the minimum spacing between the starts of two operations. During that window `ready` is low, and a request that is waiting is held off rather than lost. A write either replaces the whole word or, in byte mode, changes a single lane and leaves the other lanes of the word as they were. Legal parameter values satisfy 1 <= `ACC_LAT` <= `CYC_TIME` and `CYC_TIME` >= 2.

Top module: `hsmem`

## Requirements
- R1: After reset, `ready` is 1, `mfc` is 0, `rdata` is 0, and every word of the array reads back as 0.
- R2: A request is accepted at a rising clock edge where `ready` is 1 and exactly one of `rd_req` and `wr_req` is 1. In the cycle after the acceptance edge, `ready` is 0.
- R3: `mfc` is 1 for exactly one cycle. That cycle is the one that follows the `ACC_LAT`-th rising edge after the acceptance edge. At all other times `mfc` is 0.
- R4: For an accepted read, `rdata` carries the entire word selected by `addr[ADDR_W-1:2]` in the cycle where `mfc` is 1. `addr[1:0]` and `byte_op` have no effect on the returned value.
- R5: A write with `byte_op` = 0 stores all of `wdata` into the word selected by `addr[ADDR_W-1:2]`. `addr[1:0]` is ignored.
- R6: A write with `byte_op` = 1 stores `wdata[7:0]` into byte lane k = `addr[1:0]`, which is bits 8k+7 down to 8k of the word. The other three lanes keep their previous values.
- R7: `ready` returns to 1 in the cycle after the (`CYC_TIME`-1)-th edge following acceptance. A request held high while `ready` is 0 is therefore accepted exactly `CYC_TIME` edges after the previous acceptance and is not dropped.
- R8: When `rd_req` and `wr_req` are both 1, nothing is accepted. `ready` stays 1, no `mfc` pulse occurs, and the memory contents are unchanged.
- R9: `rdata` changes only in a cycle where `mfc` is 1 for a read. A write leaves `rdata` holding the last read value.
- R10: `addr`, `wdata` and `byte_op` are captured at the acceptance edge. Changing them while the operation is in progress has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the request |
| wdata | input | DATA_W | Write data: the full word, or byte in bits 7:0 for a byte write |
| rd_req | input | 1 | Read strobe, held until accepted |
| wr_req | input | 1 | Write strobe, held until accepted |
| byte_op | input | 1 | 1 selects a single-byte write |
| ready | output | 1 | 1 when a new request can be accepted |
| mfc | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word read by the last completed read |

## Verification
The bench concentrates on four hazards.

- Byte writes are aimed at every lane and followed by read-back. A design with a wrong lane decode, or one that writes the whole word, would corrupt neighbouring bytes.
- Requests are held through the busy window and issued back to back. A design that counted the cycle time off by one, or that lost a request made while busy, would show the wrong spacing between acceptances or a missing completion.
- Simultaneous read and write strobes are driven. A design that took either one would pulse `mfc` or alter the memory.
- Address and data are scrambled right after acceptance, and writes are checked against a stable `rdata`. These catch a design that samples its inputs late or lets a write disturb the read data.

// File: rtl/hsmem_pkg.sv
`timescale 1ns/1ps
package hsmem_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_READ  = 2'd1,
        REQ_WRITE = 2'd2
    } req_kind_e;

    // Exactly one strobe makes a request; both or neither make none.
    function automatic req_kind_e decode_req(input logic rd, input logic wr);
        if (rd && !wr) begin
            return REQ_READ;
        end
        if (wr && !rd) begin
            return REQ_WRITE;
        end
        return REQ_IDLE;
    endfunction

endpackage

// File: rtl/hsmem_seq.sv
`timescale 1ns/1ps
module hsmem_seq
    import hsmem_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ACC_LAT  = 3,
    parameter int CYC_TIME = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              byte_op,
    output logic              ready,
    output logic              mfc,
    output logic              acc_en,
    output logic              acc_wr,
    output logic              acc_byte,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata
);

    localparam int CW = $clog2(CYC_TIME + 1);

    typedef struct packed {
        logic              busy;
        logic              pend;
        logic [CW-1:0]     cnt;
        logic              mfc;
        logic              wr;
        logic              bmode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t      s_d, s_q;
    req_kind_e kind;
    logic      accept;
    logic      fire;

    always_comb begin
        s_d     = s_q;
        s_d.mfc = 1'b0;
        kind    = decode_req(rd_req, wr_req);
        accept  = !s_q.busy && (kind != REQ_IDLE);
        fire    = s_q.pend && (s_q.cnt == CW'(ACC_LAT - 1));

        if (s_q.busy || s_q.pend) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (fire) begin
            s_d.pend = 1'b0;
            s_d.mfc  = 1'b1;
        end
        if (s_q.busy && (s_q.cnt == CW'(CYC_TIME - 2))) begin
            s_d.busy = 1'b0;
        end
        // A new acceptance may coincide with the previous access firing
        // (only when ACC_LAT == CYC_TIME); the access above used s_q.
        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.pend  = 1'b1;
            s_d.cnt   = '0;
            s_d.wr    = (kind == REQ_WRITE);
            s_d.bmode = byte_op;
            s_d.addr  = addr;
            s_d.wdata = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready     = !s_q.busy;
    assign mfc       = s_q.mfc;
    assign acc_en    = fire;
    assign acc_wr    = s_q.wr;
    assign acc_byte  = s_q.bmode;
    assign acc_addr  = s_q.addr;
    assign acc_wdata = s_q.wdata;

endmodule

// File: rtl/hsmem_store.sv
`timescale 1ns/1ps
module hsmem_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_byte,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANES = DATA_W / 8;
    localparam int LB    = $clog2(LANES);
    localparam int WI_W  = ADDR_W - LB;
    localparam int DEPTH = 1 << WI_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [WI_W-1:0]   widx;
    logic [LB-1:0]     lane;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] merged;
    logic [LANES-1:0]  lane_we;

    assign widx     = acc_addr[ADDR_W-1:LB];
    assign lane     = acc_addr[LB-1:0];
    assign old_word = mem_q[widx];

    // Per-lane write enable and merge: a byte write takes its byte from
    // the low lane of the data and lands it in the addressed lane only.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_we[l] = !acc_byte || (lane == LB'(l));
        assign merged[8*l +: 8] = !lane_we[l] ? old_word[8*l +: 8] :
                                  acc_byte    ? acc_wdata[7:0]     :
                                                acc_wdata[8*l +: 8];
    end

    always_comb begin
        mem_d   = mem_q;
        rdata_d = rdata_q;
        if (acc_en) begin
            if (acc_wr) begin
                mem_d[widx] = merged;
            end else begin
                rdata_d = old_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            mem_q   <= mem_d;
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hsmem.sv
`timescale 1ns/1ps
module hsmem #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ACC_LAT  = 3,
    parameter int CYC_TIME = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              byte_op,
    output logic              ready,
    output logic              mfc,
    output logic [DATA_W-1:0] rdata
);

    logic              acc_en;
    logic              acc_wr;
    logic              acc_byte;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;

    hsmem_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ACC_LAT (ACC_LAT),
        .CYC_TIME(CYC_TIME)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .byte_op  (byte_op),
        .ready    (ready),
        .mfc      (mfc),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_byte (acc_byte),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata)
    );

    hsmem_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_byte (acc_byte),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .rdata    (rdata)
    );

endmodule

// File: rtl/hsmem_chk.sv
`timescale 1ns/1ps
module hsmem_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ACC_LAT  = 3,
    parameter int CYC_TIME = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              wr_req,
    input logic              ready,
    input logic              mfc,
    input logic [DATA_W-1:0] rdata
);

    logic        accept_w;
    logic [15:0] since_q;

    assign accept_w = ready && (rd_req ^ wr_req);

    // Cycles since the last acceptance edge, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 16'hFFFF;
        end else if (accept_w) begin
            since_q <= '0;
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept_w |=> !ready); // R2

    AST_MFC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mfc |=> !mfc); // R3

    AST_MFC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        mfc |-> ((since_q == 16'(ACC_LAT)) ||
                 ((ACC_LAT == CYC_TIME) && (since_q == 16'd0)))); // R3

    AST_READY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (since_q >= 16'(CYC_TIME - 1))); // R7

    AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_req && wr_req) |=> ready); // R8

    AST_RDATA_ONLY_ON_MFC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> mfc); // R9

endmodule

bind hsmem hsmem_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ACC_LAT (ACC_LAT),
    .CYC_TIME(CYC_TIME)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_req(rd_req),
    .wr_req(wr_req),
    .ready (ready),
    .mfc   (mfc),
    .rdata (rdata)
);

// File: tb/tb_hsmem.sv
`timescale 1ns/1ps
module tb_hsmem;

    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int ACC   = 3;
    localparam int CYC   = 5;
    localparam int DEPTH = 1 << (AW - 2);
    localparam int LAST  = (ACC > CYC - 1) ? ACC : CYC - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          rd_req = 1'b0;
    logic          wr_req = 1'b0;
    logic          byte_op = 1'b0;
    logic          ready;
    logic          mfc;
    logic [DW-1:0] rdata;

    int            n_tests = 0;
    int            n_fail = 0;
    int            edges = 0;
    int            prev_acc = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] last_rd = '0;

    hsmem #(.ADDR_W(AW), .DATA_W(DW), .ACC_LAT(ACC), .CYC_TIME(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_req(rd_req), .wr_req(wr_req), .byte_op(byte_op),
        .ready(ready), .mfc(mfc), .rdata(rdata)
    );

    always #10 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] apply_write(input logic [DW-1:0] old,
            input bit bm, input logic [1:0] lane, input logic [DW-1:0] d);
        logic [DW-1:0] r;
        r = old;
        if (bm) begin
            r[8*lane +: 8] = d[7:0];
        end else begin
            r = d;
        end
        return r;
    endfunction

    // Called at a negedge. Returns at the negedge after edge LAST of the op.
    task automatic do_op(input bit is_wr, input bit bm, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit hold, input bit want_gap,
                         input string tag);
        int            guard;
        int            acc;
        logic [DW-1:0] exp;
        rd_req = !is_wr; wr_req = is_wr; byte_op = bm; addr = a; wdata = d;
        guard = 0;
        while (!ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        #1;
        acc = edges;
        if (want_gap) begin
            chk((acc - prev_acc) == CYC, "R7", "acceptance spacing",
                DW'(acc - prev_acc), DW'(CYC));
        end
        prev_acc = acc;
        exp = model[a[AW-1:2]];
        if (is_wr) begin
            model[a[AW-1:2]] = apply_write(exp, bm, a[1:0], d);
        end
        @(negedge clk);
        chk(ready == 1'b0, "R2", "ready after accept", DW'(ready), 0);
        chk(mfc == 1'b0, "R3", "mfc at accept", DW'(mfc), 0);
        if (!hold) begin
            rd_req = 1'b0; wr_req = 1'b0;
            addr = AW'($urandom); wdata = $urandom; byte_op = 1'($urandom);
        end
        for (int i = 1; i <= LAST; i++) begin
            @(negedge clk);
            chk(mfc == (i == ACC), "R3", "mfc timing", DW'(mfc), DW'(i == ACC));
            if (i == ACC) begin
                if (!is_wr) begin
                    chk(rdata == exp, tag, "read data", rdata, exp);
                    last_rd = rdata;
                end else begin
                    chk(rdata == last_rd, "R9", "rdata after write", rdata, last_rd);
                end
            end
            chk(ready == (i >= CYC - 1), "R7", "ready timing", DW'(ready),
                DW'(i >= CYC - 1));
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [AW-1:0] ra;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ready == 1'b1, "R1", "ready after reset", DW'(ready), 1);
        chk(mfc == 1'b0, "R1", "mfc after reset", DW'(mfc), 0);
        chk(rdata == '0, "R1", "rdata after reset", rdata, 0);
        do_op(0, 0, 8'h00, 0, 0, 0, "R1");
        do_op(0, 1, 8'h7D, 0, 0, 1, "R1");
        do_op(0, 0, 8'hFF, 0, 0, 1, "R1");

        // R5: word write ignores low address bits
        do_op(1, 0, 8'h13, 32'hDEADBEEF, 0, 1, "R5");
        do_op(0, 0, 8'h10, 0, 0, 1, "R5");
        do_op(0, 1, 8'h12, 0, 0, 1, "R4");

        // R6: byte writes into every lane of one word
        do_op(1, 0, 8'h40, 32'h11223344, 0, 1, "R6");
        for (int l = 0; l < 4; l++) begin
            do_op(1, 1, AW'(8'h40 + l), DW'(32'hA0 + l) | 32'h5500_0000, 0, 1, "R6");
            do_op(0, 0, 8'h40, 0, 0, 1, "R6");
        end

        // R7: request held through busy window, then back to back
        do_op(1, 0, 8'h80, 32'hCAFE0001, 1, 1, "R7");
        do_op(1, 0, 8'h80, 32'hCAFE0001, 0, 1, "R7");
        do_op(0, 0, 8'h80, 0, 0, 1, "R7");

        // R8: both strobes together are ignored
        repeat (2) @(negedge clk);
        rd_req = 1'b1; wr_req = 1'b1; addr = 8'h80; wdata = 32'h0BAD0BAD; byte_op = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(mfc == 1'b0, "R8", "mfc with both strobes", DW'(mfc), 0);
            chk(ready == 1'b1, "R8", "ready with both strobes", DW'(ready), 1);
        end
        rd_req = 1'b0; wr_req = 1'b0;
        @(negedge clk);
        do_op(0, 0, 8'h80, 0, 0, 0, "R8");

        // R10: inputs change right after acceptance (do_op scrambles them)
        do_op(1, 0, 8'hC4, 32'h600DF00D, 0, 1, "R10");
        do_op(0, 0, 8'hC4, 0, 0, 1, "R10");

        // Random mix, sometimes with idle gaps
        for (int n = 0; n < 400; n++) begin
            bit gap;
            gap = ($urandom % 4) == 0;
            if (gap) begin
                rd_req = 1'b0; wr_req = 1'b0;
                repeat (1 + $urandom % 3) @(negedge clk);
            end
            ra = AW'($urandom % 32);
            do_op(1'($urandom), 1'($urandom), ra, $urandom, 0, !gap, "R4");
        end
        // final sweep of a range against the model
        for (int w = 0; w < 8; w++) begin
            do_op(0, 0, AW'(w * 4), 0, 0, 1, "R6");
        end
        finish_run();
    end

endmodule